// File: doc/BRIEF.md
# Single-Digit Decimal Adder with Six-Correction

This block adds two binary-coded decimal digits plus an incoming decimal carry. It returns one decimal digit and a decimal carry. The block is purely combinational.

It works in two stages. First, a 4-bit binary ripple adder forms a raw 5-bit total, which runs from 0 to 19. Next, a small detector marks any raw total that is not a legal decimal digit. That is either a total with a carry out of the binary adder, or a 4-bit code from ten to fifteen. When the mark is set, a second 4-bit adder adds six to the raw nibble and drops the overflow bit. The mark itself becomes the decimal carry.

The caller must supply legal digits (0 to 9). Chaining digits into multi-digit numbers is left to the surrounding logic. Parameter `CIN_EN` selects whether the carry input takes part in the sum. It defaults to 1, and with 0 the input is ignored.

Top module: `bcd_digit_adder`

## Requirements
- R1: For legal digits A, B and carry input C, the result satisfies 10·carry_out + sum_dig = A + B + C.
- R2: For legal digits, sum_dig is always in the range 0 to 9.
- R3: carry_out is 1 exactly when A + B + C is 10 or more.
- R4: When A + B + C is 9 or less, sum_dig equals that binary total unchanged.
- R5: When A + B + C is 10 to 15, sum_dig equals the total plus six, taken modulo 16.
- R6: When A + B + C is 16 to 19, sum_dig equals the low nibble of the total plus six, taken modulo 16.
- R7: 9 + 9 with carry input 0 gives sum_dig 8 and carry_out 1. With carry input 1 it gives sum_dig 9 and carry_out 1.
- R8: With the default CIN_EN = 1, raising carry_in adds exactly one to the decimal result 10·carry_out + sum_dig.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dig_a | input | 4 | First decimal digit, binary coded |
| dig_b | input | 4 | Second decimal digit, binary coded |
| carry_in | input | 1 | Decimal carry from a lower digit |
| sum_dig | output | 4 | Corrected decimal result digit |
| carry_out | output | 1 | Decimal carry to the next digit |

## Verification
The bench sweeps all 200 combinations of two legal digits and the carry input. It compares each result with a reference computed in decimal arithmetic. Each case is also sorted by its raw total into three bands: no correction (0–9), correction without a binary carry (10–15), and correction after a binary carry (16–19). This sorting separates a faulty detector term from a faulty correction adder. Separate checks cover the largest sums, 9 + 9 with and without the carry input. They also compare each carry-in pair directly, so that a lost or doubled carry input shows up.

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder #(
  parameter int  W      = 4,
  parameter bit  CIN_EN = 1'b1
) (
  input  logic [W-1:0] dig_a,
  input  logic [W-1:0] dig_b,
  input  logic         carry_in,
  output logic [W-1:0] sum_dig,
  output logic         carry_out
);
  localparam logic [W-1:0] SIX = W'(6);

  logic [W:0]   rip;
  logic [W-1:0] raw;
  logic         fix;

  generate
    if (CIN_EN) begin : g_cin
      assign rip[0] = carry_in;
    end else begin : g_nocin
      assign rip[0] = 1'b0;
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      assign raw[i]   = dig_a[i] ^ dig_b[i] ^ rip[i];
      assign rip[i+1] = (dig_a[i] & dig_b[i]) | ((dig_a[i] ^ dig_b[i]) & rip[i]);
    end
  endgenerate

  assign fix       = rip[W] | (raw[3] & (raw[2] | raw[1]));
  assign sum_dig   = raw + (fix ? SIX : '0);
  assign carry_out = fix;

  logic [5:0] tot;
  logic       legal;
  assign tot   = 6'(dig_a) + 6'(dig_b) + 6'(CIN_EN ? carry_in : 1'b0);
  assign legal = (dig_a <= 4'd9) && (dig_b <= 4'd9);

  always_comb begin
    if (legal) begin
      a_r1_value:   assert (6'(carry_out) * 6'd10 + 6'(sum_dig) == tot);
      a_r2_digit:   assert (sum_dig <= 4'd9);
      a_r3_carry:   assert (carry_out == (tot >= 6'd10));
      a_r4_nofix:   assert (carry_out || sum_dig == raw);
    end
  end
endmodule

// File: tb/sim_bcd_digit_adder.sv
module sim_bcd_digit_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a, b;
  logic       ci;
  logic [3:0] s;
  logic       co;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  bcd_digit_adder u0 (.dig_a(a), .dig_b(b), .carry_in(ci), .sum_dig(s), .carry_out(co));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d ci=%0d actual=%0d expected=%0d", req, a, b, ci, act, exp);
    end
  endtask

  task automatic apply(input int x, input int y, input int c);
    @(negedge clk);
    a = 4'(x); b = 4'(y); ci = c[0];
    @(posedge clk);
    #1;
  endtask

  initial begin
    a = 0; b = 0; ci = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset-time zero sum", int'(s), 0);
    chk("R3 reset-time zero carry", int'(co), 0);
    rst = 1'b0;

    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        for (int c = 0; c < 2; c++) begin
          int t;
          t = x + y + c;
          apply(x, y, c);
          chk("R1 decimal value", int'(co) * 10 + int'(s), t);
          chk("R2 digit range", int'(s <= 4'd9), 1);
          chk("R3 carry", int'(co), int'(t >= 10));
          if (t <= 9)       chk("R4 uncorrected", int'(s), t);
          else if (t <= 15) chk("R5 corrected code", int'(s), (t + 6) % 16);
          else              chk("R6 corrected overflow", int'(s), ((t % 16) + 6) % 16);
        end

    apply(9, 9, 0);
    chk("R7 9+9 sum", int'(s), 8);
    chk("R7 9+9 carry", int'(co), 1);
    apply(9, 9, 1);
    chk("R7 9+9+1 sum", int'(s), 9);
    chk("R7 9+9+1 carry", int'(co), 1);

    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++) begin
        int r0;
        apply(x, y, 0);
        r0 = int'(co) * 10 + int'(s);
        apply(x, y, 1);
        chk("R8 carry-in step", int'(co) * 10 + int'(s), r0 + 1);
      end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule